// File: doc/BRIEF.md
# Partitioned 8x16 Fractional Multiplier

This block is a SIMD multiply unit for pixel arithmetic. Each lane multiplies an unsigned 8-bit pixel component by a signed 16-bit coefficient. It keeps a rounded 16-bit fractional slice of the product. A 9-bit operation code picks one of seven variants, which differ in how pixels and coefficients are steered into the lanes:

- per-lane coefficients;
- one coefficient broadcast to every lane;
- the high or low byte taken out of each 16-bit lane;
- a two-lane form that widens its results into 32-bit halves.

An operation is presented together with a valid strobe. Its 64-bit result comes back with its own valid strobe exactly two clock cycles later. The unit takes a new operation every cycle. Register fetch and writeback belong to the surrounding datapath.

Top module: `fracmul8x16`

## Requirements
- R1: While `rst_n` is low and after it is released, `res_valid` is 0 and `res` is all zeros until the first result arrives.
- R2: When `op_valid` is 1 on a rising clock edge, `res_valid` is 1 after the second following edge and carries that operation's result. `res_valid` is 0 after any edge pair whose first edge saw `op_valid` low.
- R3: Each lane product P is the 24-bit two's-complement value pixel(unsigned) × coef(signed). The lane result is P[23:8] + P[7], truncated to 16 bits.
- R4: Op code 0x031: lane i (0..3) uses pixel `op_a[8i+7:8i]` and coefficient `op_b[16i+15:16i]`. The result goes to `res[16i+15:16i]`.
- R5: Op code 0x033 uses `op_b[31:16]` and op code 0x035 uses `op_b[15:0]` as the coefficient for all four lanes. Pixels are `op_a[8i+7:8i]` and results go to `res[16i+15:16i]`.
- R6: Op code 0x036 takes pixel `op_a[16i+15:16i+8]` and op code 0x037 takes pixel `op_a[16i+7:16i]`. Both use coefficient `op_b[16i+15:16i]`, with results in `res[16i+15:16i]`.
- R7: Op codes 0x038 (high byte) and 0x039 (low byte) process lanes 0 and 1 only. Pixels are `op_a[16i+15:16i+8]` or `op_a[16i+7:16i]`, and the coefficient is `op_b[16i+15:16i]`. Lane i's result is placed at `res[32i+22:32i+7]`, and all other result bits are 0.
- R8: Any other op code yields an all-zero `res`, still accompanied by `res_valid`.
- R9: Operations issued on consecutive cycles each return their own result, in order, on consecutive cycles.
- R10: When no result is delivered (`res_valid` low), `res` keeps the last delivered value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 9 | Variant selector |
| op_a | input | 64 | Pixel operand |
| op_b | input | 64 | Coefficient operand |
| res_valid | output | 1 | Result present |
| res | output | 64 | Packed rounded products |

## Verification
The bench builds the block with its default parameters: four lanes, 8-bit pixels and 16-bit coefficients. These are the only values at which the op-code semantics are defined, and they put the full 24-bit signed product range within reach. Directed vectors target the rounding boundary at product bit 7, the extreme product 255 × -32768, and the broadcast halves. They also check the 7-bit placement in the two-lane form. Random vectors mix all seven op codes with stray codes and with gaps and bursts in `op_valid`, so back-to-back issue and result holding are both exercised.

// File: rtl/fracmul_pkg.sv
package fracmul_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_LANE,
    K_BC_HI,
    K_BC_LO,
    K_BYTE_HI,
    K_BYTE_LO,
    K_PAIR_HI,
    K_PAIR_LO
  } mul_kind_e;

  localparam logic [8:0] OPC_LANE    = 9'h031;
  localparam logic [8:0] OPC_BC_HI   = 9'h033;
  localparam logic [8:0] OPC_BC_LO   = 9'h035;
  localparam logic [8:0] OPC_BYTE_HI = 9'h036;
  localparam logic [8:0] OPC_BYTE_LO = 9'h037;
  localparam logic [8:0] OPC_PAIR_HI = 9'h038;
  localparam logic [8:0] OPC_PAIR_LO = 9'h039;

  function automatic mul_kind_e decode_kind(input logic [8:0] opc);
    case (opc)
      OPC_LANE:    decode_kind = K_LANE;
      OPC_BC_HI:   decode_kind = K_BC_HI;
      OPC_BC_LO:   decode_kind = K_BC_LO;
      OPC_BYTE_HI: decode_kind = K_BYTE_HI;
      OPC_BYTE_LO: decode_kind = K_BYTE_LO;
      OPC_PAIR_HI: decode_kind = K_PAIR_HI;
      OPC_PAIR_LO: decode_kind = K_PAIR_LO;
      default:     decode_kind = K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fracmul_steer.sv
module fracmul_steer
  import fracmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  localparam int DW    = LANES * COEF_W
) (
  input  mul_kind_e                  kind,
  input  logic [DW-1:0]              opa,
  input  logic [DW-1:0]              opb,
  output logic [LANES-1:0][PIX_W-1:0]  pix,
  output logic [LANES-1:0][COEF_W-1:0] coef,
  output logic [LANES-1:0]           lane_on,
  output logic                       pair
);

  localparam int PAIRS = LANES / 2;

  always_comb begin
    pair = (kind == K_PAIR_HI) || (kind == K_PAIR_LO);
    for (int i = 0; i < LANES; i++) begin
      coef[i]    = opb[COEF_W*i +: COEF_W];
      pix[i]     = opa[PIX_W*i +: PIX_W];
      lane_on[i] = 1'b1;
      case (kind)
        K_LANE: ;
        K_BC_HI: coef[i] = opb[COEF_W +: COEF_W];
        K_BC_LO: coef[i] = opb[0 +: COEF_W];
        K_BYTE_HI: pix[i] = opa[COEF_W*i + PIX_W +: PIX_W];
        K_BYTE_LO: pix[i] = opa[COEF_W*i +: PIX_W];
        K_PAIR_HI: begin
          pix[i]     = opa[COEF_W*i + PIX_W +: PIX_W];
          lane_on[i] = (i < PAIRS);
        end
        K_PAIR_LO: begin
          pix[i]     = opa[COEF_W*i +: PIX_W];
          lane_on[i] = (i < PAIRS);
        end
        default: lane_on[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/fracmul_lane.sv
module fracmul_lane #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  localparam int PROD_W = PIX_W + COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PIX_W-1:0]  pix,
  input  logic [COEF_W-1:0] coef,
  input  logic              lane_on,
  output logic [PROD_W-1:0] prod_q
);

  logic signed [PIX_W:0]    pix_s;
  logic signed [COEF_W-1:0] coef_s;
  logic signed [PROD_W:0]   full;
  logic [PROD_W-1:0]        prod_d;

  always_comb begin
    pix_s  = $signed({1'b0, pix});
    coef_s = $signed(coef);
    full   = pix_s * coef_s;
    prod_d = lane_on ? full[PROD_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prod_q <= '0;
    else if (en) prod_q <= prod_d;
  end

  // R8
  lane_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !lane_on) |=> (prod_q == '0));

  // R10
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(prod_q));

endmodule

// File: rtl/fracmul_pack.sv
module fracmul_pack #(
  parameter int LANES  = 4,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  localparam int PROD_W = PIX_W + COEF_W,
  localparam int DW     = LANES * COEF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         pair,
  input  logic [LANES-1:0][PROD_W-1:0] prod,
  output logic [DW-1:0]                res_q
);

  localparam int PAIRS = LANES / 2;
  localparam int SLOT  = 2 * COEF_W;
  localparam int SHIFT = PIX_W - 1;

  logic [LANES-1:0][COEF_W-1:0] scaled;
  logic [DW-1:0] res_d;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_round
      assign scaled[g] = prod[g][PROD_W-1:PIX_W]
                       + {{(COEF_W-1){1'b0}}, prod[g][PIX_W-1]};
    end
  endgenerate

  always_comb begin
    res_d = '0;
    if (pair) begin
      for (int i = 0; i < PAIRS; i++)
        res_d[SLOT*i + SHIFT +: COEF_W] = scaled[i];
    end else begin
      for (int i = 0; i < LANES; i++)
        res_d[COEF_W*i +: COEF_W] = scaled[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  res_q <= '0;
    else if (en) res_q <= res_d;
  end

  // R7
  pair_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pair) |=> (res_q[SHIFT-1:0] == '0 && res_q[SLOT-1:SHIFT+COEF_W] == '0
                      && res_q[SLOT +: SHIFT] == '0 && res_q[DW-1:SLOT+SHIFT+COEF_W] == '0));

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(res_q));

endmodule

// File: rtl/fracmul8x16.sv
module fracmul8x16
  import fracmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  localparam int DW     = LANES * COEF_W,
  localparam int PROD_W = PIX_W + COEF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [8:0]    op_code,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          res_valid,
  output logic [DW-1:0] res
);

  mul_kind_e                    kind;
  logic [LANES-1:0][PIX_W-1:0]  pix;
  logic [LANES-1:0][COEF_W-1:0] coef;
  logic [LANES-1:0]             lane_on;
  logic                         pair_d, pair_q;
  logic [LANES-1:0][PROD_W-1:0] prod_q;
  logic                         s1_valid;

  assign kind = decode_kind(op_code);

  fracmul_steer #(.LANES(LANES), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_steer (
    .kind(kind), .opa(op_a), .opb(op_b),
    .pix(pix), .coef(coef), .lane_on(lane_on), .pair(pair_d)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      fracmul_lane #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .en(op_valid),
        .pix(pix[g]), .coef(coef[g]), .lane_on(lane_on[g]),
        .prod_q(prod_q[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      s1_valid  <= op_valid;
      res_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pair_q <= 1'b0;
    else if (op_valid) pair_q <= pair_d;
  end

  fracmul_pack #(.LANES(LANES), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .en(s1_valid), .pair(pair_q),
    .prod(prod_q), .res_q(res)
  );

  // R2
  stage1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> s1_valid);

  // R2
  stage2_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> res_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !res_valid);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(res));

endmodule

// File: tb/fracmul8x16_bench.sv
`timescale 1ns/1ps
module fracmul8x16_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [8:0]  op_code;
  logic [63:0] op_a, op_b;
  logic        res_valid;
  logic [63:0] res;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [63:0] ex1, ex2, last_res;
  logic        v1, v2;
  string       t1, t2;

  always #2 clk = ~clk;

  fracmul8x16 u_fracmul8x16 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res(res)
  );

  function automatic logic [15:0] rmul(input logic [7:0] p, input logic [15:0] c);
    logic signed [31:0] pr;
    pr = $signed({24'd0, p}) * $signed({{16{c[15]}}, c});
    rmul = pr[23:8] + {15'd0, pr[7]};
  endfunction

  function automatic logic [63:0] model(input logic [8:0] op, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      case (op)
        9'h031: r[16*i +: 16] = rmul(a[8*i +: 8], b[16*i +: 16]);
        9'h033: r[16*i +: 16] = rmul(a[8*i +: 8], b[31:16]);
        9'h035: r[16*i +: 16] = rmul(a[8*i +: 8], b[15:0]);
        9'h036: r[16*i +: 16] = rmul(a[16*i+8 +: 8], b[16*i +: 16]);
        9'h037: r[16*i +: 16] = rmul(a[16*i +: 8], b[16*i +: 16]);
        9'h038: if (i < 2) r[32*i+7 +: 16] = rmul(a[16*i+8 +: 8], b[16*i +: 16]);
        9'h039: if (i < 2) r[32*i+7 +: 16] = rmul(a[16*i +: 8], b[16*i +: 16]);
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [8:0] op);
    case (op)
      9'h031: return "R4/R3";
      9'h033, 9'h035: return "R5";
      9'h036, 9'h037: return "R6";
      9'h038, 9'h039: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_out();
    n_vec++;
    if (res_valid !== v2) begin
      n_bad++;
      $display("FAIL %s R2 res_valid actual %0b expected %0b", t2, res_valid, v2);
    end else if (v2 && res !== ex2) begin
      n_bad++;
      $display("FAIL %s R9 res actual %h expected %h", t2, res, ex2);
    end else if (!v2 && res !== last_res) begin
      n_bad++;
      $display("FAIL R10 held res actual %h expected %h", res, last_res);
    end
    if (v2) last_res = ex2;
  endtask

  task automatic step(input logic v, input logic [8:0] op, input logic [63:0] a,
                      input logic [63:0] b);
    @(negedge clk);
    check_out();
    ex2 = ex1; v2 = v1; t2 = t1;
    ex1 = model(op, a, b); v1 = v; t1 = tag_of(op);
    op_valid = v; op_code = op; op_a = a; op_b = b;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog actual %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [8:0] ops [7];
    void'($urandom(32'h5eed_1234));
    ops[0] = 9'h031; ops[1] = 9'h033; ops[2] = 9'h035; ops[3] = 9'h036;
    ops[4] = 9'h037; ops[5] = 9'h038; ops[6] = 9'h039;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_a = '0; op_b = '0;
    ex1 = '0; ex2 = '0; last_res = '0; v1 = 0; v2 = 0; t1 = "R1"; t2 = "R1";
    repeat (3) @(negedge clk);
    // R1: reset state
    n_vec++;
    if (res_valid !== 1'b0 || res !== 64'd0) begin
      n_bad++;
      $display("FAIL R1 reset actual %0b/%h expected 0/0", res_valid, res);
    end
    rst_n = 1'b1;
    step(0, 9'h000, '0, '0);
    step(0, 9'h000, '0, '0);
    // R3 rounding boundary: 1*0x80 -> 1, 1*0x7f -> 0, 255*-32768
    step(1, 9'h031, 64'h0000_0000_ff01_0101, 64'h8000_0080_007f_0100);
    // R3 negative products with round bit
    step(1, 9'h031, 64'h0000_0000_0303_ff80, 64'hffff_fff1_ff81_ffff);
    // R5 broadcast halves
    step(1, 9'h033, 64'h0000_0000_80ff_017f, 64'h0000_0000_c123_0abc);
    step(1, 9'h035, 64'h0000_0000_80ff_017f, 64'h0000_0000_c123_0abc);
    // R6 byte select
    step(1, 9'h036, 64'hff01_80aa_0155_7fff, 64'h7fff_8000_1234_fedc);
    step(1, 9'h037, 64'hff01_80aa_0155_7fff, 64'h7fff_8000_1234_fedc);
    // R7 two-lane placement with full-range value
    step(1, 9'h038, 64'hffff_ffff_ffff_ff00, 64'hffff_ffff_8000_7fff);
    step(1, 9'h039, 64'hffff_ffff_ffff_00ff, 64'hffff_ffff_7fff_8000);
    // R8 unsupported op
    step(1, 9'h032, 64'hffff_ffff_ffff_ffff, 64'h7fff_7fff_7fff_7fff);
    step(1, 9'h1ff, 64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321);
    // R10 gap
    step(0, 9'h031, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff);
    step(0, 9'h031, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff);
    // R9 random mixed stream
    for (int k = 0; k < 4000; k++) begin
      logic [8:0] op;
      logic v;
      op = ops[$urandom_range(0, 6)];
      if ($urandom_range(0, 15) == 0) op = 9'($urandom);
      v = ($urandom_range(0, 4) != 0);
      step(v, op, {$urandom, $urandom}, {$urandom, $urandom});
    end
    step(0, 9'h000, '0, '0);
    step(0, 9'h000, '0, '0);
    step(0, 9'h000, '0, '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule